// File: doc/BRIEF.md
# Clock-Crossing Memory-Mapped Slave to Register Port Bridge

This block is a 32-bit memory-mapped slave that sits in a processor clock domain. It replays each bus write or read as a register-port operation in a second clock domain that has no fixed phase or frequency relation to the first. On the register side a write is a one-cycle strobe, like a RAM write, that carries a word address, data and four byte enables. A read is a one-cycle request. The address stays constant until the register logic answers with a data word and a valid strobe.

The bridge handles one operation at a time. It accepts a command from the bus and holds waitrequest high while the command crosses, runs and is acknowledged. For a read, it also holds waitrequest until the returned word is registered on the bus side. Waitrequest then drops for exactly one bus cycle, and in that cycle the transfer completes. Each direction of the crossing uses a toggle that passes through a two-flop synchroniser. The command fields and the returned word stay frozen while their toggle crosses, so they can be sampled directly.

Top module: `avmm_reg_bridge`

## Requirements
- R1: After reset, and while either reset is held, waitrequest is 1 and neither the register write strobe nor the read request is driven.
- R2: Each accepted bus write produces exactly one single-cycle register write strobe. The register address equals the bus word address and the register write data equals the bus write data.
- R3: The four byte enables reach the register port unchanged. Bit i qualifies data bits [8i+7:8i], for every one of the 16 combinations.
- R4: Waitrequest stays 1 until the register side has finished the current operation. It then goes to 0 for exactly one bus cycle, and only while the command is presented.
- R5: Each accepted bus read produces exactly one single-cycle read request carrying the bus word address. The register address does not change from the request until read valid is seen.
- R6: In the bus cycle where waitrequest is 0 for a read, readdata equals the word the register side presented together with read valid.
- R7: Only one operation is in flight at a time. The write strobe and the read request are never active together, and no write strobe occurs while a read is waiting for its data.
- R8: A read whose data returns late keeps waitrequest at 1 for the whole wait, for any read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor-side clock |
| bus_rst_n | input | 1 | Processor-side synchronous reset, active low |
| reg_clk | input | 1 | Register-side clock |
| reg_rst_n | input | 1 | Register-side synchronous reset, active low |
| avs_address | input | ADDR_W | Bus word address |
| avs_write | input | 1 | Bus write command |
| avs_read | input | 1 | Bus read command |
| avs_writedata | input | DATA_W | Bus write data |
| avs_byteenable | input | DATA_W/8 | Bus byte enables |
| avs_waitrequest | output | 1 | Stall; 0 marks the completing cycle |
| avs_readdata | output | DATA_W | Read word, valid when waitrequest is 0 |
| reg_wr_en | output | 1 | Register write strobe |
| reg_addr | output | ADDR_W | Register word address, shared by writes and reads |
| reg_wr_data | output | DATA_W | Register write data |
| reg_wr_be | output | DATA_W/8 | Register write byte enables |
| reg_rd_req | output | 1 | Register read request |
| reg_rd_data | input | DATA_W | Register read data |
| reg_rd_valid | input | 1 | Register read data qualifier |

## Verification
The bench builds the bridge with ADDR_W set to 4, so all 16 word addresses can be written and read back. At one address every byte-enable pattern is swept. The register clock runs at a period that is not a multiple of the bus clock, so the toggle crossings land at shifting phases. Read latencies of zero to three register cycles, plus one very long wait, exercise the address hold and the readdata capture across the whole range of handshake timings.

// File: rtl/bridge_pkg.sv
// Shared state encodings for the two halves of the clock-crossing bridge.
package bridge_pkg;
    typedef enum logic [1:0] {
        B_IDLE = 2'd0,
        B_BUSY = 2'd1,
        B_DONE = 2'd2
    } bus_st_t;

    typedef enum logic {
        R_IDLE = 1'b0,
        R_WAIT = 1'b1
    } reg_st_t;
endpackage

// File: rtl/bridge_tsync.sv
// Multi-flop synchroniser for a single toggle level.
// Assumes the input changes at most once per several destination cycles.
module bridge_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // each stage resamples its predecessor (stage 0 takes the async input)
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_bus_side.sv
// Bus-domain half: latches one command, flips the request toggle, waits for
// the synchronised acknowledge, registers read data, then releases
// waitrequest for one cycle. Assumes the master holds its command until then.
module bridge_bus_side
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int STAGES = 2,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] avs_address,
    input  logic              avs_write,
    input  logic              avs_read,
    input  logic [DATA_W-1:0] avs_writedata,
    input  logic [BE_W-1:0]   avs_byteenable,
    output logic              avs_waitrequest,
    output logic [DATA_W-1:0] avs_readdata,
    input  logic              ack_tog_async,
    input  logic [DATA_W-1:0] rd_word_async,
    output logic              req_tog,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [BE_W-1:0]   cmd_be
);
    bus_st_t     state;
    logic        ack_sync;
    logic        ack_seen;
    logic [DATA_W-1:0] rdata_q;

    bridge_tsync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tog_async),
        .q     (ack_sync)
    );

    // command acceptance, completion detection and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= B_IDLE;
            req_tog  <= 1'b0;
            ack_seen <= 1'b0;
            cmd_wr   <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
            cmd_be   <= '0;
            rdata_q  <= '0;
        end else begin
            case (state)
                B_IDLE: if (avs_write || avs_read) begin
                    cmd_wr   <= avs_write;
                    cmd_addr <= avs_address;
                    cmd_data <= avs_writedata;
                    cmd_be   <= avs_byteenable;
                    req_tog  <= ~req_tog;
                    state    <= B_BUSY;
                end
                B_BUSY: if (ack_sync != ack_seen) begin
                    ack_seen <= ack_sync;
                    if (!cmd_wr) rdata_q <= rd_word_async;
                    state    <= B_DONE;
                end
                default: state <= B_IDLE;
            endcase
        end
    end

    assign avs_waitrequest = (state != B_DONE);
    assign avs_readdata    = rdata_q;
endmodule

// File: rtl/bridge_reg_side.sv
// Register-domain half: detects a request toggle edge, issues a one-cycle
// write strobe or read request, holds the address through the read, keeps
// the returned word and flips the acknowledge toggle. Assumes the bus-side
// command fields are frozen while a request is outstanding.
module bridge_reg_side
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int STAGES = 2,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tog_async,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [BE_W-1:0]   cmd_be,
    output logic              ack_tog,
    output logic [DATA_W-1:0] rd_word,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [BE_W-1:0]   reg_wr_be,
    output logic              reg_rd_req,
    input  logic [DATA_W-1:0] reg_rd_data,
    input  logic              reg_rd_valid
);
    reg_st_t state;
    logic    req_sync;
    logic    req_seen;

    bridge_tsync #(.STAGES(STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tog_async),
        .q     (req_sync)
    );

    // request decode, strobe generation, read wait and acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= R_IDLE;
            req_seen    <= 1'b0;
            ack_tog     <= 1'b0;
            rd_word     <= '0;
            reg_wr_en   <= 1'b0;
            reg_rd_req  <= 1'b0;
            reg_addr    <= '0;
            reg_wr_data <= '0;
            reg_wr_be   <= '0;
        end else begin
            reg_wr_en  <= 1'b0;
            reg_rd_req <= 1'b0;
            case (state)
                R_IDLE: if (req_sync != req_seen) begin
                    req_seen <= req_sync;
                    reg_addr <= cmd_addr;
                    if (cmd_wr) begin
                        reg_wr_en   <= 1'b1;
                        reg_wr_data <= cmd_data;
                        reg_wr_be   <= cmd_be;
                        ack_tog     <= ~ack_tog;
                    end else begin
                        reg_rd_req  <= 1'b1;
                        state       <= R_WAIT;
                    end
                end
                default: if (reg_rd_valid) begin
                    rd_word <= reg_rd_data;
                    ack_tog <= ~ack_tog;
                    state   <= R_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/avmm_reg_bridge.sv
// Top level: joins the bus-domain and register-domain halves. The only
// signals crossing are two toggles plus command and read-word buses that
// are held stable while their toggle travels. Both resets should be
// applied together.
module avmm_reg_bridge #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int STAGES = 2,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              reg_clk,
    input  logic              reg_rst_n,
    input  logic [ADDR_W-1:0] avs_address,
    input  logic              avs_write,
    input  logic              avs_read,
    input  logic [DATA_W-1:0] avs_writedata,
    input  logic [BE_W-1:0]   avs_byteenable,
    output logic              avs_waitrequest,
    output logic [DATA_W-1:0] avs_readdata,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [BE_W-1:0]   reg_wr_be,
    output logic              reg_rd_req,
    input  logic [DATA_W-1:0] reg_rd_data,
    input  logic              reg_rd_valid
);
    logic              req_tog;
    logic              ack_tog;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic [BE_W-1:0]   cmd_be;
    logic [DATA_W-1:0] rd_word;

    bridge_bus_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES)) u_bus (
        .clk             (bus_clk),
        .rst_n           (bus_rst_n),
        .avs_address     (avs_address),
        .avs_write       (avs_write),
        .avs_read        (avs_read),
        .avs_writedata   (avs_writedata),
        .avs_byteenable  (avs_byteenable),
        .avs_waitrequest (avs_waitrequest),
        .avs_readdata    (avs_readdata),
        .ack_tog_async   (ack_tog),
        .rd_word_async   (rd_word),
        .req_tog         (req_tog),
        .cmd_wr          (cmd_wr),
        .cmd_addr        (cmd_addr),
        .cmd_data        (cmd_data),
        .cmd_be          (cmd_be)
    );

    bridge_reg_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES)) u_reg (
        .clk           (reg_clk),
        .rst_n         (reg_rst_n),
        .req_tog_async (req_tog),
        .cmd_wr        (cmd_wr),
        .cmd_addr      (cmd_addr),
        .cmd_data      (cmd_data),
        .cmd_be        (cmd_be),
        .ack_tog       (ack_tog),
        .rd_word       (rd_word),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wr_data   (reg_wr_data),
        .reg_wr_be     (reg_wr_be),
        .reg_rd_req    (reg_rd_req),
        .reg_rd_data   (reg_rd_data),
        .reg_rd_valid  (reg_rd_valid)
    );
endmodule

// File: rtl/bridge_chk.sv
// Property checker for the bridge; attached to every instance by bind.
module bridge_chk #(
    parameter int ADDR_W = 16
) (
    input logic              bus_clk,
    input logic              bus_rst_n,
    input logic              reg_clk,
    input logic              reg_rst_n,
    input logic              avs_write,
    input logic              avs_read,
    input logic              avs_waitrequest,
    input logic              reg_wr_en,
    input logic              reg_rd_req,
    input logic              reg_rd_valid,
    input logic [ADDR_W-1:0] reg_addr
);
    logic rd_pend;

    // tracks a read between its request and its valid strobe
    always_ff @(posedge reg_clk) begin
        if (!reg_rst_n)        rd_pend <= 1'b0;
        else if (reg_rd_valid) rd_pend <= 1'b0;
        else if (reg_rd_req)   rd_pend <= 1'b1;
    end

    AST_WAIT_ONE_CYCLE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !avs_waitrequest |=> avs_waitrequest); // R4
    AST_DONE_NEEDS_CMD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !avs_waitrequest |-> (avs_write || avs_read)); // R4
    AST_RDREQ_PULSE: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        reg_rd_req |=> !reg_rd_req); // R5
    AST_ADDR_HOLD: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        ((rd_pend || reg_rd_req) && !reg_rd_valid) |=> $stable(reg_addr)); // R5
    AST_WR_RD_EXCL: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        !(reg_wr_en && reg_rd_req)); // R7
    AST_NO_WR_IN_READ: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        rd_pend |-> !reg_wr_en); // R7
endmodule

bind avmm_reg_bridge bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .bus_clk         (bus_clk),
    .bus_rst_n       (bus_rst_n),
    .reg_clk         (reg_clk),
    .reg_rst_n       (reg_rst_n),
    .avs_write       (avs_write),
    .avs_read        (avs_read),
    .avs_waitrequest (avs_waitrequest),
    .reg_wr_en       (reg_wr_en),
    .reg_rd_req      (reg_rd_req),
    .reg_rd_valid    (reg_rd_valid),
    .reg_addr        (reg_addr)
);

// File: tb/sim_avmm_reg_bridge.sv
`timescale 1ns/1ps
module sim_avmm_reg_bridge;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          bus_clk = 1'b0;
    logic          reg_clk = 1'b0;
    logic          bus_rst_n = 1'b0;
    logic          reg_rst_n = 1'b0;
    logic [AW-1:0] avs_address = '0;
    logic          avs_write = 1'b0;
    logic          avs_read = 1'b0;
    logic [DW-1:0] avs_writedata = '0;
    logic [3:0]    avs_byteenable = '0;
    logic          avs_waitrequest;
    logic [DW-1:0] avs_readdata;
    logic          reg_wr_en;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wr_data;
    logic [3:0]    reg_wr_be;
    logic          reg_rd_req;
    logic [DW-1:0] reg_rd_data = '0;
    logic          reg_rd_valid = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // register-side model state
    int            wr_cnt = 0;
    int            rd_cnt = 0;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    logic [3:0]    s_be;
    int            rd_lat = 0;

    always #2.5 bus_clk = ~bus_clk;
    always #3.5 reg_clk = ~reg_clk;

    avmm_reg_bridge #(.ADDR_W(AW), .DATA_W(DW), .STAGES(2)) u0 (
        .bus_clk         (bus_clk),
        .bus_rst_n       (bus_rst_n),
        .reg_clk         (reg_clk),
        .reg_rst_n       (reg_rst_n),
        .avs_address     (avs_address),
        .avs_write       (avs_write),
        .avs_read        (avs_read),
        .avs_writedata   (avs_writedata),
        .avs_byteenable  (avs_byteenable),
        .avs_waitrequest (avs_waitrequest),
        .avs_readdata    (avs_readdata),
        .reg_wr_en       (reg_wr_en),
        .reg_addr        (reg_addr),
        .reg_wr_data     (reg_wr_data),
        .reg_wr_be       (reg_wr_be),
        .reg_rd_req      (reg_rd_req),
        .reg_rd_data     (reg_rd_data),
        .reg_rd_valid    (reg_rd_valid)
    );

    function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a, input int lat);
        return 32'h5A00_0000 + ({28'd0, a} << 12) + lat[DW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // register-side responder: records strobes, answers reads after rd_lat cycles
    initial begin
        forever begin
            @(negedge reg_clk);
            reg_rd_valid = 1'b0;
            if (reg_wr_en) begin
                wr_cnt++;
                s_addr = reg_addr;
                s_data = reg_wr_data;
                s_be   = reg_wr_be;
                check(!reg_rd_req, "R7 strobe and request together", 32'(reg_rd_req), 0);
            end
            if (reg_rd_req) begin
                rd_cnt++;
                s_addr = reg_addr;
                for (int k = 0; k < rd_lat; k++) begin
                    @(negedge reg_clk);
                    check(reg_addr == s_addr, "R5 address held during read",
                          32'(reg_addr), 32'(s_addr));
                    check(!reg_wr_en, "R7 no write while read waits", 32'(reg_wr_en), 0);
                end
                reg_rd_data  = rd_val(s_addr, rd_lat);
                reg_rd_valid = 1'b1;
            end
        end
    end

    // one bus transfer; returns readdata seen in the completing cycle and its length
    task automatic bus_xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [3:0] be, output logic [DW-1:0] rdata,
                            output int cycles);
        int n = 0;
        @(negedge bus_clk);
        avs_write      = wr;
        avs_read       = !wr;
        avs_address    = a;
        avs_writedata  = d;
        avs_byteenable = be;
        rdata = '0;
        forever begin
            @(negedge bus_clk);
            n++;
            if (!avs_waitrequest) begin
                rdata = avs_readdata;
                break;
            end
            if (n > 5000) begin
                check(1'b0, "R4 transfer never completed", 32'(n), 0);
                break;
            end
        end
        cycles = n;
        @(posedge bus_clk);
        #1;
        avs_write = 1'b0;
        avs_read  = 1'b0;
        @(negedge bus_clk);
        check(avs_waitrequest, "R4 waitrequest low for one cycle only",
              32'(avs_waitrequest), 1);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [3:0] be);
        logic [DW-1:0] rd;
        int cyc;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        bus_xfer(1'b1, a, d, be, rd, cyc);
        check(wr_cnt == w0 + 1, "R2 one strobe per write", 32'(wr_cnt - w0), 1);
        check(rd_cnt == r0, "R7 no read request on write", 32'(rd_cnt - r0), 0);
        check(s_addr == a, "R2 write address", 32'(s_addr), 32'(a));
        check(s_data == d, "R2 write data", s_data, d);
        check(s_be == be, "R3 byte enables", 32'(s_be), 32'(be));
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int lat, output int cyc);
        logic [DW-1:0] rd;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        rd_lat = lat;
        bus_xfer(1'b0, a, 32'hFFFF_FFFF, 4'hF, rd, cyc);
        check(rd_cnt == r0 + 1, "R5 one request per read", 32'(rd_cnt - r0), 1);
        check(wr_cnt == w0, "R7 no write strobe on read", 32'(wr_cnt - w0), 0);
        check(s_addr == a, "R5 read address", 32'(s_addr), 32'(a));
        check(rd == rd_val(a, lat), "R6 readdata", rd, rd_val(a, lat));
    endtask

    // watchdog
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc;
        // R1: outputs during and after reset
        repeat (8) begin
            @(negedge bus_clk);
            check(avs_waitrequest === 1'b1, "R1 waitrequest in reset", 32'(avs_waitrequest), 1);
        end
        @(negedge reg_clk);
        check(reg_wr_en === 1'b0 && reg_rd_req === 1'b0, "R1 register strobes in reset",
              32'({reg_wr_en, reg_rd_req}), 0);
        bus_rst_n = 1'b1;
        reg_rst_n = 1'b1;
        repeat (6) begin
            @(negedge bus_clk);
            check(avs_waitrequest === 1'b1, "R1 waitrequest idle", 32'(avs_waitrequest), 1);
            check(wr_cnt == 0 && rd_cnt == 0, "R1 no strobe after reset", 32'(wr_cnt + rd_cnt), 0);
        end

        // R2: every address, two byte-enable patterns
        for (int a = 0; a < 16; a++) begin
            do_write(AW'(a), 32'h1111_1111 * a ^ 32'hC3A5_0F96, 4'hF);
            do_write(AW'(a), ~(32'h0101_0101 * a), 4'(a));
        end
        // R3: all byte-enable combinations at one address
        for (int b = 0; b < 16; b++)
            do_write(AW'(5), 32'hDEAD_0000 | b, 4'(b));

        // R5 R6: every address, latencies 0..3
        for (int a = 0; a < 16; a++)
            do_read(AW'(a), a % 4, cyc);

        // R8: long read latency keeps waitrequest high throughout
        do_read(AW'(9), 60, cyc);
        check(cyc >= 60, "R8 waitrequest held over long read", 32'(cyc), 60);

        // R7: alternating back-to-back writes and reads
        for (int a = 0; a < 8; a++) begin
            do_write(AW'(15 - a), 32'h0BAD_F00D + a, 4'(a + 3));
            do_read(AW'(a), 1, cyc);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule